// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block sits on an 8-bit game cartridge between the console buses and the program and pattern ROMs. CPU writes into a small register window load two files of four bank numbers each: one file banks program ROM in four 8 KiB CPU windows, the other banks pattern ROM in four 2 KiB PPU windows. Each access picks its register directly from the address bits of the window being touched, and the produced bank number is placed above the untouched low address bits.

The top 64 bytes of CPU space, which hold the interrupt vectors and a short boot stub, always come from the final program bank no matter what the registers hold. The block also produces the program ROM enable from the ROM-select strobe and the enable and write strobes for a 2 KiB save RAM window. All bank registers are sampled into a system clock domain; a register load happens on a falling edge of M2 seen by that clock.

Top module: `mapper_ctrl`

## Requirements
- R1: A write (cpu_rw low) to $6000-$6003 loads cpu_d[5:0] into program register cpu_a[1:0] at the first clk edge where M2 is low after having been high in the previous cycle.
- R2: Under the same M2 rule, a write to $6004-$6007 loads cpu_d[7:0] into pattern register cpu_a[1:0]; cpu_a[2] selects pattern file over program file.
- R3: A read cycle (cpu_rw high), or any write outside $6000-$6007, leaves every bank register unchanged.
- R4: For CPU addresses $8000-$FFBF, prg_addr = {program register[cpu_a[14:13]], cpu_a[12:0]}.
- R5: For CPU addresses $FFC0-$FFFF, prg_addr[18:13] = 63 whatever the registers hold, with prg_addr[12:0] = cpu_a[12:0].
- R6: chr_addr = {pattern register[ppu_a[12:11]], ppu_a[10:0]}.
- R7: After reset all program registers hold 63 and all pattern registers hold 0.
- R8: ram_ce_n is low only when cpu_a is in $6800-$6FFF and M2 is high; ram_we_n is low only when ram_ce_n is low and cpu_rw is low.
- R9: prg_ce_n follows romsel_n; addresses in $6000-$6007 never enable the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the CPU bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_a | input | 16 | CPU address |
| cpu_d | input | 8 | CPU write data |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| m2 | input | 1 | CPU M2 phase |
| romsel_n | input | 1 | ROM-select strobe, low for $8000-$FFFF |
| ppu_a | input | 13 | PPU pattern address |
| prg_addr | output | 19 | Banked program ROM address |
| chr_addr | output | 19 | Banked pattern ROM address |
| prg_ce_n | output | 1 | Program ROM enable, active low |
| ram_ce_n | output | 1 | Save RAM enable, active low |
| ram_we_n | output | 1 | Save RAM write strobe, active low |

## Verification
The bench aims at the edges of the decoded ranges: $6007 against $6008, $67FF and $7000 against the RAM window, and $FFBF against $FFC0, where an off-by-one decode would either bank the vectors or lose the last ordinary bank bytes. It issues reads and writes into the register window with M2 still high, which a design strobing on the wrong phase or ignoring cpu_rw would turn into stray register loads. Swapping A2 or the A1:A0 index would show as bank numbers landing in the wrong window on the following random reads.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int CPU_AW     = 16;
  localparam int PRG_BANK_W = 6;
  localparam int CHR_BANK_W = 8;
  localparam int PRG_OFS_W  = 13;
  localparam int CHR_OFS_W  = 11;
  localparam int NREG       = 4;
  localparam int IDX_W      = $clog2(NREG);
  localparam logic [CPU_AW-1:0] REG_BASE = 16'h6000;
  localparam logic [CPU_AW-1:0] RAM_LO   = 16'h6800;
  localparam logic [CPU_AW-1:0] RAM_HI   = 16'h6FFF;
  localparam logic [CPU_AW-1:0] VEC_LO   = 16'hFFC0;

  function automatic logic in_reg_window(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1:3] == REG_BASE[CPU_AW-1:3];
  endfunction

  function automatic logic in_ram_window(input logic [CPU_AW-1:0] a);
    return (a >= RAM_LO) && (a <= RAM_HI);
  endfunction

  function automatic logic in_vector(input logic [CPU_AW-1:0] a);
    return a >= VEC_LO;
  endfunction
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile #(
  parameter int W = 8,
  parameter int N = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  localparam int IW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0] din,
  output logic [N*W-1:0] flat
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                     q <= RST_VAL;
      else if (we && idx == IW'(i))   q <= din;
    end
    assign flat[i*W +: W] = q;
  end
endmodule

// File: rtl/mapper_prg_xlat.sv
module mapper_prg_xlat
  import mapper_pkg::*;
(
  input  logic [CPU_AW-1:0]          cpu_a,
  input  logic [NREG*PRG_BANK_W-1:0] banks,
  output logic [PRG_BANK_W+PRG_OFS_W-1:0] prg_addr
);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = '1;
  logic [IDX_W-1:0]      win;
  logic [PRG_BANK_W-1:0] bank;
  always_comb begin
    win  = cpu_a[PRG_OFS_W +: IDX_W];
    bank = in_vector(cpu_a) ? LAST_BANK : banks[win*PRG_BANK_W +: PRG_BANK_W];
    prg_addr = {bank, cpu_a[PRG_OFS_W-1:0]};
  end
endmodule

// File: rtl/mapper_chr_xlat.sv
module mapper_chr_xlat
  import mapper_pkg::*;
(
  input  logic [CHR_OFS_W+IDX_W-1:0]  ppu_a,
  input  logic [NREG*CHR_BANK_W-1:0]  banks,
  output logic [CHR_BANK_W+CHR_OFS_W-1:0] chr_addr
);
  logic [IDX_W-1:0] win;
  always_comb begin
    win      = ppu_a[CHR_OFS_W +: IDX_W];
    chr_addr = {banks[win*CHR_BANK_W +: CHR_BANK_W], ppu_a[CHR_OFS_W-1:0]};
  end
endmodule

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_a,
  input  logic [7:0]           cpu_d,
  input  logic                 cpu_rw,
  input  logic                 m2,
  input  logic                 romsel_n,
  input  logic [12:0]          ppu_a,
  output logic [18:0]          prg_addr,
  output logic [18:0]          chr_addr,
  output logic                 prg_ce_n,
  output logic                 ram_ce_n,
  output logic                 ram_we_n
);
  localparam logic [PRG_BANK_W-1:0] PRG_RST = '1;

  logic m2_q;
  logic m2_fall;
  logic reg_hit;
  logic wr_prg_stb;
  logic wr_chr_stb;
  logic ram_sel;
  logic [NREG*PRG_BANK_W-1:0] prg_flat;
  logic [NREG*CHR_BANK_W-1:0] chr_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= m2;
  end

  assign m2_fall    = m2_q && !m2;
  assign reg_hit    = in_reg_window(cpu_a) && !cpu_rw && m2_fall;
  assign wr_prg_stb = reg_hit && !cpu_a[2];
  assign wr_chr_stb = reg_hit &&  cpu_a[2];

  mapper_regfile #(.W(PRG_BANK_W), .N(NREG), .RST_VAL(PRG_RST)) u_prg_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_prg_stb), .idx(cpu_a[IDX_W-1:0]),
    .din(cpu_d[PRG_BANK_W-1:0]), .flat(prg_flat));

  mapper_regfile #(.W(CHR_BANK_W), .N(NREG), .RST_VAL('0)) u_chr_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_chr_stb), .idx(cpu_a[IDX_W-1:0]),
    .din(cpu_d[CHR_BANK_W-1:0]), .flat(chr_flat));

  mapper_prg_xlat u_prg_xlat (.cpu_a(cpu_a), .banks(prg_flat), .prg_addr(prg_addr));
  mapper_chr_xlat u_chr_xlat (.ppu_a(ppu_a), .banks(chr_flat), .chr_addr(chr_addr));

  assign ram_sel  = in_ram_window(cpu_a) && m2;
  assign prg_ce_n = romsel_n;
  assign ram_ce_n = !ram_sel;
  assign ram_we_n = !(ram_sel && !cpu_rw);
endmodule

// File: rtl/mapper_ctrl_chk.sv
module mapper_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_a,
  input logic        cpu_rw,
  input logic        m2,
  input logic        ram_ce_n,
  input logic        ram_we_n,
  input logic [18:0] prg_addr,
  input logic        wr_prg_stb,
  input logic        wr_chr_stb,
  input logic [23:0] prg_flat
);
  a_r1_prg_stb_decode: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prg_stb |-> (!cpu_rw && !m2 && cpu_a >= 16'h6000 && cpu_a <= 16'h6003));
  a_r2_chr_stb_decode: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chr_stb |-> (!cpu_rw && !m2 && cpu_a >= 16'h6004 && cpu_a <= 16'h6007));
  a_r3_one_file: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_prg_stb, wr_chr_stb}));
  a_r3_read_keeps_regs: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rw |=> $stable(prg_flat));
  a_r5_vector_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_a >= 16'hFFC0) |-> (prg_addr[18:13] == 6'd63));
  a_r8_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ce_n |-> (m2 && cpu_a >= 16'h6800 && cpu_a <= 16'h6FFF));
  a_r8_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && !cpu_rw));
endmodule

bind mapper_ctrl mapper_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_a(cpu_a), .cpu_rw(cpu_rw), .m2(m2),
  .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .prg_addr(prg_addr),
  .wr_prg_stb(wr_prg_stb), .wr_chr_stb(wr_chr_stb), .prg_flat(prg_flat));

// File: tb/mapper_ctrl_bench.sv
module mapper_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_a = 16'h0000;
  logic [7:0]  cpu_d = 0;
  logic cpu_rw = 1, m2 = 0, romsel_n = 1;
  logic [12:0] ppu_a = 0;
  logic [18:0] prg_addr, chr_addr;
  logic prg_ce_n, ram_ce_n, ram_we_n;
  int checks = 0, errors = 0;
  logic [5:0] mprg [4];
  logic [7:0] mchr [4];

  always #10 clk = ~clk;

  mapper_ctrl u_mapper_ctrl (.*);

  function automatic logic [18:0] exp_prg(input logic [15:0] a);
    if (a >= 16'hFFC0) return {6'd63, a[12:0]};
    return {mprg[a[14:13]], a[12:0]};
  endfunction
  function automatic logic [18:0] exp_chr(input logic [12:0] p);
    return {mchr[p[12:11]], p[10:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // bus cycle: address phase with M2 high, then M2 falls
  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw);
    @(negedge clk); cpu_a = a; cpu_d = d; cpu_rw = rw; m2 = 1;
    romsel_n = !a[15];
    @(negedge clk); m2 = 0;
    @(negedge clk);
    if (!rw && a[15:3] == 13'h0C00) begin
      if (!a[2]) mprg[a[1:0]] = d[5:0]; else mchr[a[1:0]] = d;
    end
  endtask

  task automatic probe_prg(input logic [15:0] a, input string req);
    @(negedge clk); cpu_a = a; cpu_rw = 1; romsel_n = !a[15]; #1;
    chk(req, 32'(prg_addr), 32'(exp_prg(a)));
  endtask

  task automatic probe_chr(input logic [12:0] p);
    @(negedge clk); ppu_a = p; #1;
    chk("R6", 32'(chr_addr), 32'(exp_chr(p)));
  endtask

  task automatic check_all_regs(input string req);
    for (int w = 0; w < 4; w++) begin
      probe_prg(16'h8000 + 16'(w) * 16'h2000 + 16'h0123, req);
      probe_chr(13'(w) * 13'h0800 + 13'h055);
    end
  endtask

  initial begin
    #150000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) begin mprg[i] = 6'd63; mchr[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all_regs("R7");
    // R1 / R2 directed
    bus(16'h6000, 8'h05, 0); bus(16'h6001, 8'h11, 0);
    bus(16'h6002, 8'h2A, 0); bus(16'h6003, 8'h3E, 0);
    bus(16'h6004, 8'hA0, 0); bus(16'h6005, 8'h01, 0);
    bus(16'h6006, 8'h7F, 0); bus(16'h6007, 8'hFF, 0);
    check_all_regs("R1 R2");
    // R3: reads and near-miss writes
    bus(16'h6000, 8'h00, 1); bus(16'h6005, 8'h33, 1);
    bus(16'h6008, 8'h22, 0); bus(16'h5FFF, 8'h22, 0); bus(16'h6800, 8'h22, 0);
    check_all_regs("R3");
    // R5 boundaries
    probe_prg(16'hFFBF, "R4");
    probe_prg(16'hFFC0, "R5");
    probe_prg(16'hFFFC, "R5");
    probe_prg(16'hFFFF, "R5");
    // R8 / R9
    @(negedge clk); cpu_a = 16'h6800; m2 = 1; cpu_rw = 0; romsel_n = 1; #1;
    chk("R8", {ram_ce_n, ram_we_n}, 2'b00);
    chk("R9", prg_ce_n, 1);
    @(negedge clk); cpu_rw = 1; #1; chk("R8", {ram_ce_n, ram_we_n}, 2'b01);
    @(negedge clk); m2 = 0; #1; chk("R8", {ram_ce_n, ram_we_n}, 2'b11);
    @(negedge clk); cpu_a = 16'h6FFF; m2 = 1; #1; chk("R8", ram_ce_n, 0);
    @(negedge clk); cpu_a = 16'h7000; #1; chk("R8", ram_ce_n, 1);
    @(negedge clk); cpu_a = 16'h67FF; #1; chk("R8", ram_ce_n, 1);
    @(negedge clk); cpu_a = 16'h6003; cpu_rw = 0; #1;
    chk("R9", {ram_ce_n, ram_we_n}, 2'b11);
    @(negedge clk); cpu_a = 16'hC000; romsel_n = 0; cpu_rw = 1; #1; chk("R9", prg_ce_n, 0);
    m2 = 0;
    // random phase
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = 16'h6000 + 16'($urandom_range(0, 15));
      bus(a, 8'($urandom), 1'($urandom_range(0, 3) == 0));
      probe_prg(16'($urandom) | 16'h8000, "R4");
      probe_chr(13'($urandom));
    end
    // full bank sweep through window 0
    for (int b = 0; b < 64; b++) begin
      bus(16'h6000, 8'(b), 0);
      probe_prg(16'h8000 + 16'(b), "R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule